// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Use Interlock Controller

This block is the read-after-write hazard controller of a five-stage in-order integer pipeline with the stages fetch, decode, execute, memory and write-back. Each cycle the decode stage presents the register fields of the instruction it holds: two source indices, a destination index, a write-enable flag and a load flag. The controller keeps a shadow copy of those fields for the three older instructions in the execute, memory and write-back stages. It advances that copy on every clock edge, the same way the datapath registers advance.

From the shadow copy the controller produces two operand bypass selects for the instruction in execute. A select either keeps the register-file operand or takes the value from one of the two older pipeline registers. It also raises a stall when the instruction in decode needs the result of a load that is one stage ahead of it. During that stall the pipeline holds the program counter and the fetch/decode register, and the controller loads an empty slot into the decode/execute register. The register file writes in the first half of a cycle and reads in the second half. An instruction in decode therefore already sees a value that is being written back in the same cycle, and the controller never bypasses into decode. All pins are plain control signals with no flow control. The caller is required to keep the decode fields unchanged in the cycle after `id_stall` is high.

Top module: `hz_ctrl`

## Requirements
- R1: After reset all three shadow stages are empty. Both selects read 2'b00 and `id_stall` and `ex_bubble` are low.
- R2: An execute source operand whose index equals the destination of the write-enabled instruction one stage ahead (memory stage) gets select 2'b01.
- R3: An execute source operand whose index equals the destination of the write-enabled instruction two stages ahead (write-back stage) gets select 2'b10, provided the memory stage does not also match.
- R4: When the memory stage and the write-back stage both write the register an execute source reads, the select is 2'b01.
- R5: A producer three or more instructions older than the reader gives select 2'b00 (register file). That instruction has left the pipeline or writes back in the reader's decode cycle.
- R6: Register index 0 never produces a bypass select other than 2'b00 and never causes a stall, even when an instruction writes it.
- R7: `id_stall` and `ex_bubble` are high in exactly those cycles in which the execute stage holds a write-enabled load with a non-zero destination that matches either decode source. A non-load producer, or a load the decode instruction does not read, gives no stall.
- R8: A stall lasts one cycle. The empty slot it inserts carries neither write-enable nor load flag, so two cycles after the stall the held dependent takes its operand from the write-back stage (select 2'b10).
- R9: A dependent that directly follows a non-load producer does not stall. It is served by bypass instead.
- R10: A producer whose write-enable is low never causes a bypass select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | 5 | First source register of the decode instruction (0 when unused) |
| id_rs2 | input | 5 | Second source register of the decode instruction (0 when unused) |
| id_rd | input | 5 | Destination register of the decode instruction |
| id_we | input | 1 | Decode instruction writes its destination |
| id_ld | input | 1 | Decode instruction is a load |
| ex_fwd_a | output | 2 | Select for execute operand A: 00 register file, 01 memory stage, 10 write-back stage |
| ex_fwd_b | output | 2 | Select for execute operand B, same encoding |
| id_stall | output | 1 | Hold the program counter and the fetch/decode register this cycle |
| ex_bubble | output | 1 | Load an empty slot into decode/execute at the next edge |

## Verification
The hardest case to reach is the cycle two edges after a load-use stall. Here the held dependent must take its operand from the write-back stage while the empty slot sits between it and the load. If that slot kept any write flags, the wrong select would appear. The bench reaches this case by replaying a load followed directly by its consumer on each source port and holding the decode fields for one cycle while the stall is up. A scoreboard checks the selects and the stall flag in every cycle of each sequence, and the sequences include the add-then-four-readers case and a double writer of the same register.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int IDX_W = 5;
  localparam int NSRC  = 2;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwd_e;

  typedef struct packed {
    logic [IDX_W-1:0] rs1;
    logic [IDX_W-1:0] rs2;
    logic [IDX_W-1:0] rd;
    logic             we;
    logic             ld;
  } slot_t;

  typedef struct packed {
    logic [IDX_W-1:0] rd;
    logic             we;
  } dst_t;
endpackage

// File: rtl/hz_track.sv
module hz_track
  import hz_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t id_slot,
  input  logic  bubble,
  output slot_t idex,
  output dst_t  exmem,
  output dst_t  memwb
);
  slot_t idex_q;
  dst_t  exmem_q, memwb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      idex_q  <= bubble ? '0 : id_slot;
      exmem_q <= '{rd: idex_q.rd, we: idex_q.we};
      memwb_q <= exmem_q;
    end
  end

  assign idex  = idex_q;
  assign exmem = exmem_q;
  assign memwb = memwb_q;

  // R8
  bubble_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (!idex_q.we && !idex_q.ld));
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] src,
  input  dst_t             exmem,
  input  dst_t             memwb,
  output fwd_e             sel
);
  logic live;
  assign live = (src != '0);

  always_comb begin
    sel = FWD_RF;
    if (live && exmem.we && exmem.rd == src)
      sel = FWD_EXMEM;
    else if (live && memwb.we && memwb.rd == src)
      sel = FWD_MEMWB;
  end

  // R6
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != FWD_RF) |-> (src != '0));
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] id_rs1,
  input  logic [IDX_W-1:0] id_rs2,
  input  slot_t            idex,
  output logic             stall
);
  logic prod_ok;
  assign prod_ok = idex.ld && idex.we && (idex.rd != '0);
  assign stall   = prod_ok && ((id_rs1 == idex.rd) || (id_rs2 == idex.rd));

  // R8
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R7
  stall_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> idex.ld);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] id_rs1,
  input  logic [IDX_W-1:0] id_rs2,
  input  logic [IDX_W-1:0] id_rd,
  input  logic             id_we,
  input  logic             id_ld,
  output logic [1:0]       ex_fwd_a,
  output logic [1:0]       ex_fwd_b,
  output logic             id_stall,
  output logic             ex_bubble
);
  slot_t            id_slot, idex;
  dst_t             exmem, memwb;
  logic             stall;
  logic [IDX_W-1:0] ex_src [NSRC];
  fwd_e             fwd_sel [NSRC];

  assign id_slot = '{rs1: id_rs1, rs2: id_rs2, rd: id_rd, we: id_we, ld: id_ld};

  hz_track u_track (
    .clk(clk), .rst_n(rst_n), .id_slot(id_slot), .bubble(stall),
    .idex(idex), .exmem(exmem), .memwb(memwb)
  );

  hz_load_use u_lu (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .idex(idex), .stall(stall)
  );

  assign ex_src[0] = idex.rs1;
  assign ex_src[1] = idex.rs2;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_fwd_pick u_pick (
      .clk(clk), .rst_n(rst_n), .src(ex_src[g]),
      .exmem(exmem), .memwb(memwb), .sel(fwd_sel[g])
    );
  end

  assign ex_fwd_a  = fwd_sel[0];
  assign ex_fwd_b  = fwd_sel[1];
  assign id_stall  = stall;
  assign ex_bubble = stall;
endmodule

// File: tb/test_hz_ctrl.sv
module test_hz_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
  logic       id_we = 1'b0, id_ld = 1'b0;
  logic [1:0] ex_fwd_a, ex_fwd_b;
  logic       id_stall, ex_bubble;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       st;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  hz_ctrl i_hz_ctrl (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
    .id_we(id_we), .id_ld(id_ld), .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
    .id_stall(id_stall), .ex_bubble(ex_bubble)
  );

  // driver: presents one decode instruction per cycle, queues expected outputs
  task automatic step(input int rs1, input int rs2, input int rd, input bit we,
                      input bit ld, input logic [1:0] ea, input logic [1:0] eb,
                      input bit es, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    id_rs1 = 5'(rs1); id_rs2 = 5'(rs2); id_rd = 5'(rd); id_we = we; id_ld = ld;
    e.a = ea; e.b = eb; e.st = es; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic nop(input logic [1:0] ea, input logic [1:0] eb, input string tag);
    step(0, 0, 0, 1'b0, 1'b0, ea, eb, 1'b0, tag);
  endtask

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (ex_fwd_a !== e.a || ex_fwd_b !== e.b || id_stall !== e.st ||
            ex_bubble !== e.st) begin
          errors++;
          $display("FAIL %s: got a=%b b=%b stall=%b bubble=%b, expected a=%b b=%b stall=%b",
                   e.tag, ex_fwd_a, ex_fwd_b, id_stall, ex_bubble, e.a, e.b, e.st);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    nop(2'b00, 2'b00, "R1 reset");

    // add r1,r2,r3 then four readers of r1
    step(2, 3, 1, 1, 0,  2'b00, 2'b00, 0, "R1 add in ID");
    step(1, 5, 4, 1, 0,  2'b00, 2'b00, 0, "R9 sub after add no stall");
    step(1, 7, 6, 1, 0,  2'b01, 2'b00, 0, "R2 sub from mem stage");
    step(1, 9, 8, 1, 0,  2'b10, 2'b00, 0, "R3 and from wb stage");
    step(1, 11, 10, 1, 0, 2'b00, 2'b00, 0, "R5 or via regfile");
    nop(2'b00, 2'b00, "R5 xor via regfile");
    nop(2'b00, 2'b00, "R1 drain");

    // load r1,(r2) then readers
    step(2, 0, 1, 1, 1,  2'b00, 2'b00, 0, "R7 load in ID");
    step(1, 5, 4, 1, 0,  2'b00, 2'b00, 1, "R7 load-use stall");
    step(1, 5, 4, 1, 0,  2'b00, 2'b00, 0, "R8 held, stall once");
    step(1, 7, 6, 1, 0,  2'b10, 2'b00, 0, "R8 dependent from wb stage");
    step(1, 9, 8, 1, 0,  2'b00, 2'b00, 0, "R5 and via regfile");
    nop(2'b00, 2'b00, "R5 or via regfile");

    // double writer of r3
    step(1, 2, 3, 1, 0,  2'b00, 2'b00, 0, "R4 first writer");
    step(4, 5, 3, 1, 0,  2'b00, 2'b00, 0, "R4 second writer");
    step(3, 3, 6, 1, 0,  2'b00, 2'b00, 0, "R4 reader in ID");
    nop(2'b01, 2'b01, "R4 newer writer wins");

    // register 0
    nop(2'b00, 2'b00, "R6 drain");
    step(2, 0, 0, 1, 1,  2'b00, 2'b00, 0, "R6 load to r0");
    step(0, 0, 7, 1, 0,  2'b00, 2'b00, 0, "R6 no stall on r0");
    nop(2'b00, 2'b00, "R6 no bypass of r0");
    nop(2'b00, 2'b00, "R6 drain");

    // write-disabled producer
    step(2, 3, 9, 0, 0,  2'b00, 2'b00, 0, "R10 store in ID");
    step(9, 9, 11, 1, 0, 2'b00, 2'b00, 0, "R10 reader in ID");
    nop(2'b00, 2'b00, "R10 no bypass without write");

    // load then independent, load then rs2 reader
    step(2, 0, 12, 1, 1, 2'b00, 2'b00, 0, "R7 load r12");
    step(2, 3, 13, 1, 0, 2'b00, 2'b00, 0, "R7 independent no stall");
    step(2, 0, 14, 1, 1, 2'b00, 2'b00, 0, "R9 non-load in EX no stall");
    step(3, 14, 15, 1, 0, 2'b00, 2'b00, 1, "R7 stall on rs2");
    step(3, 14, 15, 1, 0, 2'b00, 2'b00, 0, "R8 held, stall once");
    nop(2'b00, 2'b10, "R8 rs2 from wb stage");
    nop(2'b00, 2'b00, "R1 drain");

    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected end of sequence");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule